// File: doc/BRIEF.md
# Latched GPIO input interrupt logic

This block is the input half of a sixteen-pin general-purpose I/O expander. The pins are grouped into two eight-bit ports. Every pin passes through a two-stage synchronizer. Each pin then runs in one of two modes. In live mode, software reads the current level. In latched mode, the first change after the last read is captured, and that captured value is returned until software reads the port.

A single active-low interrupt line reports that some input has moved since its port was last read. Reading a port's input register clears that port's captures and takes a new reference snapshot. The read touches only that port.

Software uses a plain register bus with an address, read and write strobes, and data in and out. Read data is registered and appears one cycle after the read strobe. The register map has two read-only input registers, at 00h for port 0 and 01h for port 1. It has two read/write latch-mode registers, at 44h for port 0 and 45h for port 1. In every register, bit i maps to pin i of that port.

Top module: `gpio_lirq_top`

## Requirements
- R1: After reset, both latch-mode registers read 00h, the interrupt line `irq_n` is high, and the reference snapshot equals the pin levels present at reset. With pins held steady, no interrupt follows.
- R2: Register 44h (port 0) and register 45h (port 1) are read/write. Writing 1 to bit i puts pin i of that port in latched mode, and a read returns the value written.
- R3: A read of 00h returns pins 7..0. A read of 01h returns pins 15..8. Read data is valid in the cycle after the read strobe. Any address other than 00h, 01h, 44h and 45h reads 00h. A write to 00h or 01h has no effect.
- R4: For a live pin, a read returns the synchronized level. The interrupt is asserted (low) while that level differs from the snapshot taken at the last read of its port. It deasserts again if the pin returns to the snapshot level before a read.
- R5: When a latched pin changes, reads return the captured value even if the pin moves back. The interrupt stays low until the port is read.
- R6: A read of a port releases that port's captures and reloads its snapshot from the current levels. The next read returns the live level, and the interrupt rises if nothing else is pending.
- R7: A read of one port leaves the captures and pending state of the other port untouched.
- R8: A latched pin and a live pin change together, and then the live pin returns. The interrupt stays low. The next read shows the latched change and the live pin's original level, and it clears the interrupt.
- R9: Switching a captured pin from latched to live does not clear the pending interrupt. A read then returns the pin's live level.
- R10: After a pin is switched from live to latched, a change on it is captured, and reads return the captured level.
- R11: A read that coincides with a pin change loses nothing. If the read reports the old level, the interrupt is raised afterwards. If it reports the new level, no interrupt follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_in | input | 16 | Asynchronous pin levels, port 1 in bits 15..8 |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; a read of 00h/01h clears that port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, valid the cycle after the read strobe |
| irq_n | output | 1 | Active-low interrupt, any pin pending |

## Verification
Two functions can land in the same cycle. The first is the read-to-clear, which reloads the snapshot and drops captures. The second is detection of a fresh change, which raises a pending condition or starts a capture. To provoke this, the bench toggles a pin and then issues the port read at a sweep of offsets, so that the read strobe falls before, on and after the cycle in which the synchronized level moves. Each outcome is judged on consistency alone. If the read reported the new level, the interrupt must stay high. If it reported the old level, the interrupt must go low. The sweep must also produce both outcomes at least once.

// File: rtl/gpio_lirq_pkg.sv
package gpio_lirq_pkg;

  // Kind of register hit by the current bus address.
  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_INPUT = 2'd1,
    KIND_LATCH = 2'd2
  } reg_kind_e;

  // Default base addresses; port p sits at base + p.
  localparam logic [7:0] DEF_IN_BASE  = 8'h00;
  localparam logic [7:0] DEF_LEN_BASE = 8'h44;

endpackage

// File: rtl/gpio_lirq_rst_sync.sv
module gpio_lirq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_lcl_n
);

  logic [1:0] rs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end

  assign rst_lcl_n = rs_q[1];

endmodule

// File: rtl/gpio_lirq_sync.sv
module gpio_lirq_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = d;
    for (int k = 1; k < STAGES; k++) begin
      stage_d[k] = stage_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) begin
        stage_q[k] <= '0;
      end
    end else begin
      for (int k = 0; k < STAGES; k++) begin
        stage_q[k] <= stage_d[k];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_lirq_port.sv
module gpio_lirq_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init,     // warm-up: follow live levels, nothing pending
  input  logic [W-1:0] lat_en,   // 1 = latched mode
  input  logic [W-1:0] live,     // synchronized pin levels
  input  logic         rd_clr,   // read of this port's input register
  output logic [W-1:0] view,     // value returned by a read
  output logic         pend      // any pin of this port pending
);

  logic [W-1:0] snap_q, snap_d;  // levels at last read
  logic [W-1:0] held_q, held_d;  // capture holding
  logic [W-1:0] hval_q, hval_d;  // captured level
  logic [W-1:0] diff;
  logic [W-1:0] cap;
  logic [W-1:0] show_held;

  assign diff = live ^ snap_q;

  always_comb begin
    snap_d = snap_q;
    held_d = held_q;
    hval_d = hval_q;
    cap    = '0;
    if (init) begin
      snap_d = live;
      held_d = '0;
      hval_d = live;
    end else if (rd_clr) begin
      snap_d = live;
      held_d = '0;
    end else begin
      cap    = lat_en & ~held_q & diff;
      held_d = held_q | cap;
      hval_d = (hval_q & ~cap) | (live & cap);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      held_q <= '0;
      hval_q <= '0;
    end else begin
      snap_q <= snap_d;
      held_q <= held_d;
      hval_q <= hval_d;
    end
  end

  assign show_held = lat_en & held_q;
  assign view      = (show_held & hval_q) | (~show_held & live);
  assign pend      = !init && (|(held_q | (~lat_en & diff)));

  // R9
  held_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_clr && !init) |=> ((held_q & $past(held_q)) == $past(held_q)));

  // R6
  clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr |=> (held_q == '0));

endmodule

// File: rtl/gpio_lirq_top.sv
module gpio_lirq_top
  import gpio_lirq_pkg::*;
#(
  parameter int         PORT_W      = 8,
  parameter int         NUM_PORTS   = 2,
  parameter int         ADDR_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] IN_BASE     = DEF_IN_BASE,
  parameter logic [7:0] LEN_BASE    = DEF_LEN_BASE
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [PORT_W*NUM_PORTS-1:0]   pin_in,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic                          bus_wr,
  input  logic                          bus_rd,
  input  logic [PORT_W-1:0]             bus_wdata,
  output logic [PORT_W-1:0]             bus_rdata,
  output logic                          irq_n
);

  localparam int PIN_W    = PORT_W * NUM_PORTS;
  localparam int PIDX_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int INIT_LEN = SYNC_STAGES + 1;
  localparam int ICNT_W   = $clog2(INIT_LEN + 1);

  logic                rst_lcl_n;
  logic [PIN_W-1:0]    pin_sync;
  logic [ICNT_W-1:0]   icnt_q, icnt_d;
  logic                init;
  reg_kind_e           kind;
  logic [PIDX_W-1:0]   kidx;
  logic [PORT_W-1:0]   lat_q   [NUM_PORTS];
  logic [PORT_W-1:0]   view_p  [NUM_PORTS];
  logic [NUM_PORTS-1:0] pend_p;
  logic [NUM_PORTS-1:0] rd_clr;
  logic [NUM_PORTS-1:0] lat_we;
  logic [PORT_W-1:0]   rdata_q, rdata_d;
  logic                irq_n_q, irq_n_d;

  gpio_lirq_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_lcl_n (rst_lcl_n)
  );

  gpio_lirq_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_lcl_n),
    .d     (pin_in),
    .q     (pin_sync)
  );

  // Warm-up counter: snapshot follows the synchronizer until it holds real levels.
  assign init = (icnt_q != ICNT_W'(INIT_LEN));

  always_comb begin
    icnt_d = icnt_q;
    if (init) begin
      icnt_d = icnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_lcl_n) begin
    if (!rst_lcl_n) begin
      icnt_q <= '0;
    end else begin
      icnt_q <= icnt_d;
    end
  end

  // Address decode
  always_comb begin
    kind = KIND_NONE;
    kidx = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (bus_addr == ADDR_W'(IN_BASE) + ADDR_W'(p)) begin
        kind = KIND_INPUT;
        kidx = PIDX_W'(p);
      end
      if (bus_addr == ADDR_W'(LEN_BASE) + ADDR_W'(p)) begin
        kind = KIND_LATCH;
        kidx = PIDX_W'(p);
      end
    end
  end

  // Per-port latch-mode registers and tracking
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign rd_clr[p] = bus_rd && (kind == KIND_INPUT) && (kidx == PIDX_W'(p));
    assign lat_we[p] = bus_wr && (kind == KIND_LATCH) && (kidx == PIDX_W'(p));

    always_ff @(posedge clk or negedge rst_lcl_n) begin
      if (!rst_lcl_n) begin
        lat_q[p] <= '0;
      end else if (lat_we[p]) begin
        lat_q[p] <= bus_wdata;
      end
    end

    gpio_lirq_port #(.W(PORT_W)) u_port (
      .clk    (clk),
      .rst_n  (rst_lcl_n),
      .init   (init),
      .lat_en (lat_q[p]),
      .live   (pin_sync[p*PORT_W +: PORT_W]),
      .rd_clr (rd_clr[p]),
      .view   (view_p[p]),
      .pend   (pend_p[p])
    );
  end

  // Read data and interrupt
  always_comb begin
    rdata_d = '0;
    case (kind)
      KIND_INPUT: rdata_d = view_p[kidx];
      KIND_LATCH: rdata_d = lat_q[kidx];
      default:    rdata_d = '0;
    endcase
    irq_n_d = ~(|pend_p);
  end

  always_ff @(posedge clk or negedge rst_lcl_n) begin
    if (!rst_lcl_n) begin
      rdata_q <= '0;
      irq_n_q <= 1'b1;
    end else begin
      if (bus_rd) begin
        rdata_q <= rdata_d;
      end
      irq_n_q <= irq_n_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_n     = irq_n_q;

  // R1
  irq_quiet_init_chk: assert property (@(posedge clk) disable iff (!rst_lcl_n)
    init |=> irq_n);

  // R2
  lat_wr_chk: assert property (@(posedge clk) disable iff (!rst_lcl_n)
    (bus_wr && bus_addr == ADDR_W'(LEN_BASE)) |=> (lat_q[0] == $past(bus_wdata)));

  // R3
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_lcl_n)
    (bus_rd && kind == KIND_NONE) |=> (bus_rdata == '0));

endmodule

// File: tb/test_gpio_lirq_top.sv
module test_gpio_lirq_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] pin_in;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic        bus_rd;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic        irq_n;

  always #5 clk = ~clk;

  gpio_lirq_top i_gpio_lirq_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_in    (pin_in),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_n     (irq_n)
  );

  typedef struct {
    logic [7:0] exp;
    logic [7:0] mask;
    string      tag;
  } sb_item_t;

  sb_item_t   sb_q[$];
  int         total = 0;
  int         bad   = 0;
  logic       rd_d;
  logic [7:0] last_rd;
  bit         done = 0;

  // Monitor: read data is valid the cycle after the strobe.
  always @(posedge clk) rd_d <= bus_rd;

  always @(negedge clk) begin
    if (rd_d === 1'b1) begin
      sb_item_t it;
      if (sb_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R3: read data %02h with no expected item, expected none", bus_rdata);
      end else begin
        it = sb_q.pop_front();
        last_rd = bus_rdata;
        if (it.mask != 8'h00) begin
          total++;
          if ((bus_rdata & it.mask) !== (it.exp & it.mask)) begin
            bad++;
            $display("FAIL %s: read got %02h expected %02h", it.tag, bus_rdata, it.exp);
          end
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t);
    sb_item_t it;
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    it.exp = e; it.mask = 8'hFF; it.tag = t;
    sb_q.push_back(it);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd_any(input logic [7:0] a);
    sb_item_t it;
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    it.exp = 8'h00; it.mask = 8'h00; it.tag = "none";
    sb_q.push_back(it);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    total++;
    if (irq_n !== e) begin
      bad++;
      $display("FAIL %s: irq_n got %b expected %b", t, irq_n, e);
    end
  endtask

  task automatic chk_val(input int act, input int e, input string t);
    total++;
    if (act != e) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", t, act, e);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run not finished, got hung expected done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int olds;
    int news;
    olds = 0; news = 0;
    rst_n = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = 8'h00; bus_wdata = 8'h00;
    pin_in = 16'h3CA5;
    tick(3);
    rst_n = 1'b1;
    tick(10);

    // R1: reset state
    chk_irq(1'b1, "R1 irq after reset");
    rd(8'h44, 8'h00, "R1 latch port0 reset");
    rd(8'h45, 8'h00, "R1 latch port1 reset");
    tick(3);
    chk_irq(1'b1, "R1 snapshot matches pins");

    // R3: map and ignored writes
    rd(8'h00, 8'hA5, "R3 port0 input");
    rd(8'h01, 8'h3C, "R3 port1 input");
    rd(8'h07, 8'h00, "R3 unmapped");
    wr(8'h00, 8'hFF);
    wr(8'h01, 8'h00);
    rd(8'h00, 8'hA5, "R3 write to input ignored");
    rd(8'h01, 8'h3C, "R3 write to input ignored");

    // R2: latch-mode registers
    wr(8'h44, 8'h0F);
    wr(8'h45, 8'h81);
    rd(8'h44, 8'h0F, "R2 readback port0");
    rd(8'h45, 8'h81, "R2 readback port1");
    wr(8'h44, 8'h00);
    wr(8'h45, 8'h00);
    rd(8'h44, 8'h00, "R2 cleared port0");

    // R4: live pin
    pin_in[7:0] = 8'hA7;
    tick(5);
    chk_irq(1'b0, "R4 live change raises irq");
    rd(8'h00, 8'hA7, "R4 live level");
    tick(3);
    chk_irq(1'b1, "R4 read clears");
    pin_in[7:0] = 8'hA5;
    tick(5);
    chk_irq(1'b0, "R4 second change");
    pin_in[7:0] = 8'hA7;
    tick(5);
    chk_irq(1'b1, "R4 return to snapshot drops irq");

    // R5 / R6: latched pin
    wr(8'h44, 8'h10);
    pin_in[7:0] = 8'hB7;
    tick(5);
    pin_in[7:0] = 8'hA7;
    tick(5);
    chk_irq(1'b0, "R5 irq held after pin returns");
    rd(8'h00, 8'hB7, "R5 captured value");
    tick(3);
    chk_irq(1'b1, "R6 read clears irq");
    rd(8'h00, 8'hA7, "R6 next read live");

    // R7: port isolation
    wr(8'h45, 8'h01);
    pin_in[15:8] = 8'h3D;
    tick(5);
    pin_in[7:0] = 8'hA6;
    tick(5);
    rd(8'h00, 8'hA6, "R7 port0 read");
    tick(3);
    chk_irq(1'b0, "R7 port1 still pending");
    pin_in[15:8] = 8'h3C;
    tick(5);
    rd(8'h01, 8'h3D, "R7 port1 capture kept");
    tick(3);
    chk_irq(1'b1, "R7 port1 read clears");
    rd(8'h01, 8'h3C, "R7 port1 live");

    // R8: latched and live change together, live returns
    pin_in[7:0] = 8'hB2;
    tick(5);
    pin_in[7:0] = 8'hB6;
    tick(5);
    chk_irq(1'b0, "R8 irq stays");
    rd(8'h00, 8'hB6, "R8 read shows latched change only");
    tick(3);
    chk_irq(1'b1, "R8 read clears");

    // R9: latched to live keeps pending, read is live
    pin_in[7:0] = 8'hA6;
    tick(5);
    wr(8'h44, 8'h00);
    tick(3);
    chk_irq(1'b0, "R9 mode change keeps irq");
    pin_in[7:0] = 8'hB6;
    tick(5);
    chk_irq(1'b0, "R9 still pending");
    rd(8'h00, 8'hB6, "R9 read returns live");
    tick(3);
    chk_irq(1'b1, "R9 read clears");

    // R10: live to latched
    pin_in[7:0] = 8'h96;
    tick(5);
    chk_irq(1'b0, "R10 live pending");
    wr(8'h44, 8'h20);
    tick(5);
    pin_in[7:0] = 8'hB6;
    tick(5);
    chk_irq(1'b0, "R10 capture pending");
    rd(8'h00, 8'h96, "R10 latched level");
    tick(3);
    chk_irq(1'b1, "R10 read clears");
    rd(8'h00, 8'hB6, "R10 live after release");
    wr(8'h44, 8'h00);
    wr(8'h45, 8'h00);

    // R11: read against a pin change at several offsets
    for (int k = 0; k < 4; k++) begin
      logic nb;
      logic seen;
      nb = ~pin_in[9];
      pin_in[9] = nb;
      tick(k);
      rd_any(8'h01);
      tick(1);
      seen = last_rd[1];
      tick(6);
      if (seen == nb) news++; else olds++;
      chk_irq((seen == nb) ? 1'b1 : 1'b0, "R11 read and change consistent");
      if (irq_n === 1'b0) begin
        rd_any(8'h01);
        tick(4);
      end
    end
    chk_val((olds > 0) ? 1 : 0, 1, "R11 sweep saw old level");
    chk_val((news > 0) ? 1 : 0, 1, "R11 sweep saw new level");
    chk_irq(1'b1, "R11 clear after sweep");

    tick(3);
    chk_val(sb_q.size(), 0, "R3 all reads returned");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule